// File: doc/BRIEF.md
# Pulse-Width Bit Receiver

The block decodes serial bits from a single-wire bus where each bit is sent as an active-high pulse followed by a low gap. The pulse length carries the bit value. A short pulse is a one and a long pulse is a zero. The width of every pulse is counted in ticks and compared with a midpoint threshold.

A read is started with a request that carries a bit count from 1 to 8. The receiver shifts that many decoded bits into a value, most significant bit first, and keeps a running count of ones for parity. It then presents the value and the parity and pulses a done strobe.

If the read runs longer than 110% of its nominal length, the read is aborted. The aborted read returns zero data and zero parity and pulses a timeout strobe. Start-bit detection, frame parsing and acknowledge handling belong to the logic around this block.

Top module: `pw_bit_rx`

## Requirements
- R1: A pulse that stays high for fewer than THRESH_TICKS ticks decodes as 1. A pulse of THRESH_TICKS ticks or more decodes as 0. The width is the number of ticks in which the synchronized line is high.
- R2: For a read of n bits, data_o holds the decoded bits in bits n-1..0, with the first received bit in bit n-1 and the last received bit in bit 0. All higher bits of data_o are zero.
- R3: On completion, parity_o equals bit 0 of the number of ones decoded in the read, which is the XOR of the bits in data_o.
- R4: After the n-th falling edge, done_o is high for exactly one cycle. data_o and parity_o then hold their values until the next read ends.
- R5: A read that has not finished within floor(n × BIT_TICKS × 11 / 10) ticks of being accepted is aborted. On abort, data_o and parity_o become 0, timeout_o pulses for one cycle, and done_o does not pulse.
- R6: The width counter saturates at its maximum value and does not wrap. A pulse longer than 2^WIDTH_W − 1 ticks therefore decodes as 0.
- R7: A request with len_i equal to 0 or greater than 8 is ignored. No read starts, and later pulses cause neither a done strobe nor a timeout strobe.
- R8: A request that arrives while a read is in progress is ignored. The running read keeps its original bit count and its bits.
- R9: Pulses whose falling edge occurs while no read is in progress do not change data_o or parity_o and do not raise either strobe.
- R10: After reset, data_o, parity_o, done_o and timeout_o are all 0.
- R11: done_o and timeout_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 1 | Bus line, asynchronous, high is the active level |
| req_i | input | 1 | One-cycle read request |
| len_i | input | 4 | Number of bits to read, 1 to 8 |
| data_o | output | 8 | Assembled value of the last read |
| parity_o | output | 1 | Bit 0 of the ones count of the last read |
| done_o | output | 1 | One-cycle strobe when a read completes |
| timeout_o | output | 1 | One-cycle strobe when a read is aborted |

## Verification
The assertions assume three things about the inputs:
- Requests are one-cycle pulses.
- The line settles through the two-flop synchronizer.
- The tick source runs continuously.

The parity property assumes that the assembled value holds only the bits of the current read. This requires that the accumulator is cleared whenever a read is accepted.

The bench uses a tick of one clock so that every pulse width is exact. It starts each request on a falling clock edge and begins driving pulses at once, which keeps each read well inside its time budget. The only exceptions are the boundary and abort cases, which are placed deliberately. The bench sweeps every value for bit counts 1 to 4 and a spread of values for counts 5 to 8.

// File: rtl/pw_rx_pkg.sv
package pw_rx_pkg;
  localparam int unsigned MAX_BITS = 8;
  localparam int unsigned LEN_W    = 4;
  localparam int unsigned CNT_W    = $clog2(MAX_BITS + 1);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_FIN  = 2'd2
  } rx_state_e;
endpackage

// File: rtl/pw_rx_tick.sv
module pw_rx_tick #(
  parameter int unsigned DIV = 25
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_pass
      logic unused;
      assign unused = clk_i ^ rst_ni;
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int unsigned CW = $clog2(DIV);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                   cnt_q <= '0;
        else if (cnt_q == CW'(DIV - 1)) cnt_q <= '0;
        else                           cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = (cnt_q == CW'(DIV - 1));
    end
  endgenerate
endmodule

// File: rtl/pw_rx_width.sv
module pw_rx_width #(
  parameter int unsigned WIDTH_W = 8,
  parameter int unsigned THRESH  = 52
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               line_i,
  input  logic               tick_i,
  output logic               bit_vld_o,
  output logic               bit_o,
  output logic               high_o,
  output logic               rise_o,
  output logic [WIDTH_W-1:0] width_o
);
  localparam logic [WIDTH_W-1:0] W_MAX = '1;

  logic sync1_q, sync2_q, prev_q;
  logic [WIDTH_W-1:0] width_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      prev_q  <= 1'b0;
    end else begin
      sync1_q <= line_i;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  assign rise_o = sync2_q & ~prev_q;
  assign high_o = sync2_q;

  // width counts ticks seen while high, the rise cycle included; saturates
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                      width_q <= '0;
    else if (rise_o)                                  width_q <= WIDTH_W'(tick_i);
    else if (sync2_q && tick_i && width_q != W_MAX)   width_q <= width_q + 1'b1;
  end

  assign width_o   = width_q;
  assign bit_vld_o = ~sync2_q & prev_q;
  assign bit_o     = (width_q < WIDTH_W'(THRESH));
endmodule

// File: rtl/pw_rx_acc.sv
module pw_rx_acc #(
  parameter int unsigned NB = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clr_i,
  input  logic                      bit_vld_i,
  input  logic                      bit_i,
  output logic [NB-1:0]             val_o,
  output logic [$clog2(NB+1)-1:0]   ones_o
);
  localparam int unsigned OW = $clog2(NB + 1);

  logic [NB-1:0] val_q;
  logic [OW-1:0] ones_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q  <= '0;
      ones_q <= '0;
    end else if (clr_i) begin
      val_q  <= '0;
      ones_q <= '0;
    end else if (bit_vld_i) begin
      val_q  <= {val_q[NB-2:0], bit_i};
      ones_q <= ones_q + OW'(bit_i);
    end
  end

  assign val_o  = val_q;
  assign ones_o = ones_q;
endmodule

// File: rtl/pw_bit_rx.sv
module pw_bit_rx
  import pw_rx_pkg::*;
#(
  parameter int unsigned TICK_DIV     = 25,
  parameter int unsigned THRESH_TICKS = 52,
  parameter int unsigned BIT_TICKS    = 79,
  parameter int unsigned WIDTH_W      = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_i,
  input  logic             req_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [7:0]       data_o,
  output logic             parity_o,
  output logic             done_o,
  output logic             timeout_o
);
  localparam int unsigned LIMIT_MAX = (MAX_BITS * BIT_TICKS * 11) / 10;
  localparam int unsigned TMR_W     = $clog2(LIMIT_MAX + 2) + 1;

  function automatic logic [TMR_W-1:0] calc_limit(input logic [LEN_W-1:0] n);
    int unsigned t;
    t = (int'(n) * BIT_TICKS * 11) / 10;
    return TMR_W'(t);
  endfunction

  rx_state_e           state_q;
  logic                busy, start, len_ok;
  logic                tick;
  logic                bit_vld, bit_val, line_high, line_rise;
  logic [WIDTH_W-1:0]  width;
  logic [MAX_BITS-1:0] acc_val;
  logic [CNT_W-1:0]    acc_ones;
  logic [CNT_W-1:0]    got_q;
  logic [LEN_W-1:0]    len_q;
  logic [TMR_W-1:0]    timer_q, limit_q;
  logic                take;

  pw_rx_tick #(.DIV(TICK_DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  pw_rx_width #(.WIDTH_W(WIDTH_W), .THRESH(THRESH_TICKS)) u_width (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .line_i   (line_i),
    .tick_i   (tick),
    .bit_vld_o(bit_vld),
    .bit_o    (bit_val),
    .high_o   (line_high),
    .rise_o   (line_rise),
    .width_o  (width)
  );

  assign busy   = (state_q != ST_IDLE);
  assign len_ok = (len_i != '0) && (len_i <= LEN_W'(MAX_BITS));
  assign start  = !busy && req_i && len_ok;
  assign take   = (state_q == ST_READ) && bit_vld;

  pw_rx_acc #(.NB(MAX_BITS)) u_acc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (start),
    .bit_vld_i(take),
    .bit_i    (bit_val),
    .val_o    (acc_val),
    .ones_o   (acc_ones)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      got_q     <= '0;
      len_q     <= '0;
      timer_q   <= '0;
      limit_q   <= '0;
      data_o    <= '0;
      parity_o  <= 1'b0;
      done_o    <= 1'b0;
      timeout_o <= 1'b0;
    end else begin
      done_o    <= 1'b0;
      timeout_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_READ;
            got_q   <= '0;
            len_q   <= len_i;
            timer_q <= '0;
            limit_q <= calc_limit(len_i);
          end
        end
        ST_READ: begin
          if (timer_q > limit_q) begin
            // budget exhausted: abort with cleared result
            data_o    <= '0;
            parity_o  <= 1'b0;
            timeout_o <= 1'b1;
            state_q   <= ST_IDLE;
          end else begin
            if (tick) timer_q <= timer_q + 1'b1;
            if (take) begin
              got_q <= got_q + 1'b1;
              if (got_q + 1'b1 == CNT_W'(len_q)) state_q <= ST_FIN;
            end
          end
        end
        ST_FIN: begin
          data_o   <= acc_val;
          parity_o <= acc_ones[0];
          done_o   <= 1'b1;
          state_q  <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pw_bit_rx_chk.sv
module pw_bit_rx_chk #(
  parameter int unsigned WIDTH_W = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_i,
  input logic [3:0]         len_i,
  input logic [7:0]         data_o,
  input logic               parity_o,
  input logic               done_o,
  input logic               timeout_o,
  input logic               busy_i,
  input logic               high_i,
  input logic               rise_i,
  input logic [WIDTH_W-1:0] width_i
);
  localparam logic [WIDTH_W-1:0] W_MAX = '1;

  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && timeout_o));                                                  // R11
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);                                                      // R4
  AST_TIMEOUT_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> !timeout_o);                                                // R5
  AST_TIMEOUT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> (data_o == 8'h00 && !parity_o));                            // R5
  AST_PARITY_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (parity_o == ^data_o));                                        // R3
  AST_WIDTH_SAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (width_i == W_MAX && high_i && !rise_i) |=> (width_i == W_MAX));          // R6
  AST_BAD_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && req_i && (len_i == 4'd0 || len_i > 4'd8)) |=> !busy_i);       // R7
  AST_STROBE_NEEDS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || timeout_o) |-> $past(busy_i));                                 // R9
  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_o && !timeout_o) |-> $stable(data_o));                             // R4
endmodule

bind pw_bit_rx pw_bit_rx_chk #(.WIDTH_W(WIDTH_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .len_i    (len_i),
  .data_o   (data_o),
  .parity_o (parity_o),
  .done_o   (done_o),
  .timeout_o(timeout_o),
  .busy_i   (busy),
  .high_i   (line_high),
  .rise_i   (line_rise),
  .width_i  (width)
);

// File: tb/pw_bit_rx_tb.sv
module pw_bit_rx_tb;
  localparam int unsigned THR = 10;
  localparam int unsigned BIT = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line = 1'b0;
  logic       req = 1'b0;
  logic [3:0] len = 4'd0;
  logic [7:0] data;
  logic       parity, done, tmo;

  int n_chk = 0;
  int n_bad = 0;
  int done_cnt = 0;
  int tmo_cnt = 0;

  always #10 clk = ~clk;

  pw_bit_rx #(.TICK_DIV(1), .THRESH_TICKS(THR), .BIT_TICKS(BIT), .WIDTH_W(5)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line), .req_i(req), .len_i(len),
    .data_o(data), .parity_o(parity), .done_o(done), .timeout_o(tmo)
  );

  always @(posedge clk) begin
    if (done) done_cnt <= done_cnt + 1;
    if (tmo)  tmo_cnt  <= tmo_cnt + 1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulse(input int hi, input int lo);
    line = 1'b1;
    repeat (hi) @(negedge clk);
    line = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    if (b) pulse(5, 11);
    else   pulse(13, 3);
  endtask

  task automatic issue(input int n);
    req = 1'b1;
    len = 4'(n);
    @(negedge clk);
    req = 1'b0;
  endtask

  // R2 R3 R4: read n bits of v and compare against arithmetic expectation
  task automatic do_read(input int n, input int v);
    int d0, t0;
    d0 = done_cnt;
    t0 = tmo_cnt;
    issue(n);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
    repeat (5) @(negedge clk);
    chk("R4 done count", done_cnt - d0, 1);
    chk("R11 no timeout", tmo_cnt - t0, 0);
    chk("R2 data", int'(data), v & ((1 << n) - 1));
    chk("R3 parity", int'(parity), $countones(v & ((1 << n) - 1)) % 2);
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int d0, t0;
    repeat (3) @(negedge clk);
    // R10: reset values
    chk("R10 data", int'(data), 0);
    chk("R10 parity", int'(parity), 0);
    chk("R10 done", int'(done), 0);
    chk("R10 timeout", int'(tmo), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 no strobes", done_cnt + tmo_cnt, 0);

    // R2 R3: exhaustive for short reads
    for (int n = 1; n <= 4; n++)
      for (int v = 0; v < (1 << n); v++) do_read(n, v);
    // spread of values for longer reads
    for (int n = 5; n <= 8; n++)
      for (int k = 0; k < 6; k++) do_read(n, (k * 73 + 5 + n) & 8'hFF);
    do_read(8, 8'hFF);
    do_read(8, 8'h00);

    // R1: threshold boundary
    d0 = done_cnt;
    issue(1); pulse(THR - 1, 7); repeat (5) @(negedge clk);
    chk("R1 width thr-1 is one", int'(data), 1);
    issue(1); pulse(THR, 6); repeat (5) @(negedge clk);
    chk("R1 width thr is zero", int'(data), 0);
    chk("R1 done count", done_cnt - d0, 2);

    // R6: 100-tick pulse (wraps to 4 in 5 bits) must read as 0
    do_read(1, 1);
    line = 1'b1;
    repeat (95) @(negedge clk);
    issue(1);
    repeat (4) @(negedge clk);
    line = 1'b0;
    repeat (8) @(negedge clk);
    chk("R6 saturated long pulse", int'(data), 0);

    // R5: abort after two of four bits
    do_read(8, 8'hFF);
    d0 = done_cnt; t0 = tmo_cnt;
    issue(4);
    send_bit(1'b1); send_bit(1'b1);
    repeat (100) @(negedge clk);
    chk("R5 timeout count", tmo_cnt - t0, 1);
    chk("R5 no done", done_cnt - d0, 0);
    chk("R5 data cleared", int'(data), 0);
    chk("R5 parity cleared", int'(parity), 0);

    // R7: illegal lengths
    do_read(3, 5);
    d0 = done_cnt; t0 = tmo_cnt;
    issue(0); send_bit(1'b1); repeat (40) @(negedge clk);
    issue(9); send_bit(1'b0); repeat (40) @(negedge clk);
    chk("R7 no strobe", (done_cnt - d0) + (tmo_cnt - t0), 0);
    chk("R7 data unchanged", int'(data), 5);

    // R9: idle pulses ignored
    d0 = done_cnt; t0 = tmo_cnt;
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    repeat (10) @(negedge clk);
    chk("R9 no strobe", (done_cnt - d0) + (tmo_cnt - t0), 0);
    chk("R9 data unchanged", int'(data), 5);
    chk("R9 parity unchanged", int'(parity), 0);
    do_read(2, 1);

    // R8: request during a read ignored
    d0 = done_cnt;
    issue(2);
    send_bit(1'b1);
    issue(1);
    send_bit(1'b0);
    repeat (5) @(negedge clk);
    chk("R8 single done", done_cnt - d0, 1);
    chk("R8 original length kept", int'(data), 2);
    chk("R8 parity", int'(parity), 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule